// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Threshold

This block holds the bytes that a serial bus sequencer has received until software collects them. The sequencer pushes one byte per cycle through a strobe. Software takes bytes out in arrival order by reading a data register, and each read removes one byte. A level event tells software that enough bytes are waiting to be worth a visit. The number of bytes that triggers the event is set in a threshold register.

Both the threshold register and the fill-level register use a count-minus-one encoding. A threshold value of N means "signal when N+1 bytes are stored". A fill-level reading of N means "N+1 bytes are stored". The empty flag tells a reading of 0 with one byte apart from a reading of 0 with no bytes. The event is compared against the live contents on every cycle, so a new threshold takes effect at once. Masking the event and the bus-side logic are outside this block.

Top module: `rx_byte_queue`

## Requirements
- R1: Bytes leave the queue in the order they were pushed. A pop of a non-empty queue places the oldest byte on `pop_data_o` on the cycle after the pop strobe, and `pop_data_o` keeps that value until the next successful pop.
- R2: `level_o` equals the number of stored bytes minus one, modulo 16, and reads 0 while the queue is empty. It updates on the cycle after a push or pop is accepted.
- R3: `empty_o` is 1 exactly when no bytes are stored. `empty_o` and `full_o` are never 1 together.
- R4: `full_o` is 1 exactly when 16 bytes are stored. The count never exceeds 16.
- R5: `thr_evt_o` is 1 whenever the stored count is at least the threshold value plus one. A threshold value of 15 therefore asserts the event only when 16 bytes are present.
- R6: A write with `thr_wr_i` high stores the 4-bit `thr_data_i` as the threshold from the next cycle on. If that threshold is below the current count minus one, `thr_evt_o` rises on that same next cycle with no push needed.
- R7: A pop while the queue is empty changes neither the count nor the flags, and `pop_data_o` keeps its last value.
- R8: A push while the queue is full and no pop is requested is dropped. The stored bytes and the count stay unchanged, and `ovf_o` goes to 1 and stays at 1 until reset.
- R9: A push and a pop in the same cycle on a full queue are both accepted. The oldest byte is read out, the new byte is appended, and the queue stays full.
- R10: After reset the queue is empty, `pop_data_o` is 0, `level_o` is 0, `ovf_o` is 0, and the threshold is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Sequencer byte strobe |
| push_data_i | input | 8 | Received byte |
| pop_i | input | 1 | Data register read strobe; removes one byte |
| pop_data_o | output | 8 | Last byte removed |
| thr_wr_i | input | 1 | Threshold register write strobe |
| thr_data_i | input | 4 | Threshold value (byte count minus one) |
| level_o | output | 4 | Stored bytes minus one; 0 when empty |
| empty_o | output | 1 | No bytes stored |
| full_o | output | 1 | 16 bytes stored |
| thr_evt_o | output | 1 | Stored count has reached threshold plus one |
| ovf_o | output | 1 | Sticky dropped-push flag |

## Verification
The bench targets the wrap of the read and write pointers after long runs of mixed traffic. An off-by-one wrap would return stale or out-of-order bytes. It pushes into a full queue, both with and without a pop in the same cycle. A design that wrongly stores or wrongly refuses the byte would show a wrong count or a lost byte. It pops past empty, where a pointer underflow would corrupt the data that follows. It also lowers the threshold below the current fill level, which exposes an event that only updates on a push. It checks the count-minus-one encoding of the level output at 0, 1 and 16 bytes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_DEPTH = 16;
  localparam int unsigned RXQ_DW    = 8;

  // {write accepted, read accepted}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } rxq_op_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          rd_req_i,
  input  logic          empty_i,
  output logic [DW-1:0] rd_data_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      rd_data_o <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= bump(wr_ptr_q);
      if (rd_en_i) begin
        rd_ptr_q  <= bump(rd_ptr_q);
        rd_data_o <= mem_q[rd_ptr_q];
      end
    end
  end

  p_wr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> wr_ptr_q == bump($past(wr_ptr_q)));
  p_empty_pop_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && empty_i) |=> ($stable(rd_data_o) && $stable(rd_ptr_q)));
endmodule

// File: rtl/rxq_level.sv
module rxq_level
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  rxq_op_e       op;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign rd_en_o = pop_i && !empty_o;
  assign wr_en_o = push_i && (!full_o || pop_i);
  assign op      = rxq_op_e'({wr_en_o, rd_en_o});
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      unique case (op)
        OP_PUSH: cnt_q <= cnt_q + 1'b1;
        OP_POP:  cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && !wr_en_o) ovf_o <= 1'b1;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  p_flags_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
  p_drop_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && ovf_o));
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  p_both_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && pop_i) |=> full_o);
endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] data_i,
  input  logic [CW-1:0] cnt_i,
  output logic          evt_o
);
  logic [AW-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= AW'(DEPTH - 1);
    else if (wr_i) thr_q <= data_i;
  end

  // count >= thr+1  <=>  count > thr
  assign evt_o = cnt_i > CW'(thr_q);

  p_thr_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> thr_q == $past(data_i));
  p_evt_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CW'(DEPTH)) |-> evt_o);
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DW    = RXQ_DW,
  parameter int unsigned DEPTH = RXQ_DEPTH,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  input  logic          thr_wr_i,
  input  logic [AW-1:0] thr_data_i,
  output logic [AW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          thr_evt_o,
  output logic          ovf_o
);
  logic          wr_en, rd_en;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_m1;

  rxq_level #(.DEPTH(DEPTH)) u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .wr_en_o (wr_en),
    .rd_en_o (rd_en),
    .cnt_o   (cnt),
    .empty_o (empty_o),
    .full_o  (full_o),
    .ovf_o   (ovf_o)
  );

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (push_data_i),
    .rd_en_i   (rd_en),
    .rd_req_i  (pop_i),
    .empty_i   (empty_o),
    .rd_data_o (pop_data_o)
  );

  rxq_thresh #(.DEPTH(DEPTH)) u_thresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (thr_wr_i),
    .data_i (thr_data_i),
    .cnt_i  (cnt),
    .evt_o  (thr_evt_o)
  );

  assign cnt_m1  = cnt - 1'b1;
  assign level_o = empty_o ? '0 : cnt_m1[AW-1:0];

  p_level_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (level_o == '0));
endmodule

// File: tb/rx_byte_queue_test.sv
module rx_byte_queue_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push = 1'b0, pop = 1'b0, thr_wr = 1'b0;
  logic [7:0] push_data = '0;
  logic [3:0] thr_data = '0;
  logic [7:0] pop_data;
  logic [3:0] level;
  logic       empty, full, evt, ovf;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  byte unsigned m_q[$];
  int  m_thr = 15;
  byte unsigned m_last = 0;
  bit  m_ovf = 0;

  always #4 clk = ~clk;

  rx_byte_queue uut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(push_data),
    .pop_i(pop), .pop_data_o(pop_data), .thr_wr_i(thr_wr), .thr_data_i(thr_data),
    .level_o(level), .empty_o(empty), .full_o(full), .thr_evt_o(evt), .ovf_o(ovf)
  );

  function automatic int exp_level(int c);
    return (c == 0) ? 0 : (c - 1) % 16;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int c = m_q.size();
    chk("R1 data", pop_data, m_last);
    chk("R2 level", level, exp_level(c));
    chk("R3 empty", empty, c == 0);
    chk("R4 full", full, c == 16);
    chk("R5 event", evt, c > m_thr);
    chk("R8 ovf", ovf, m_ovf);
  endtask

  // drive at negedge, model next state, check at following negedge
  task automatic step(bit pu, bit po, bit tw, byte unsigned d, int t);
    int c = m_q.size();
    bit ap = po && (c > 0);
    bit aw = pu && (c < 16 || po);
    push = pu; pop = po; thr_wr = tw; push_data = d; thr_data = 4'(t);
    if (ap) m_last = m_q.pop_front();
    if (aw) m_q.push_back(d);
    if (pu && !aw) m_ovf = 1;
    if (tw) m_thr = t;
    @(negedge clk);
    push = 0; pop = 0; thr_wr = 0;
    check_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check_all();
    chk("R10 reset level", level, 0);
    chk("R10 reset empty", empty, 1);

    // R7 pop on empty
    step(0, 1, 0, 0, 0);
    chk("R7 empty pop keeps empty", empty, 1);
    // R2 one byte -> level 0, not empty
    step(1, 0, 0, 8'hA5, 0);
    chk("R2 one byte level", level, 0);
    step(0, 1, 0, 0, 0);
    chk("R1 first byte out", pop_data, 8'hA5);
    step(0, 1, 0, 0, 0);
    chk("R7 hold after empty pop", pop_data, 8'hA5);

    // R5 fill to 16 with threshold 15: event only at 16
    for (int i = 0; i < 16; i++) begin
      step(1, 0, 0, 8'(i + 16), 0);
      chk("R5 thr15 event", evt, i == 15);
    end
    chk("R4 full at 16", full, 1);
    chk("R2 level at 16", level, 15);
    // R8 overflow
    step(1, 0, 0, 8'hEE, 0);
    chk("R8 ovf set", ovf, 1);
    chk("R8 count unchanged", level, 15);
    // R9 push+pop on full
    step(1, 1, 0, 8'h77, 0);
    chk("R9 stays full", full, 1);
    chk("R9 oldest out", pop_data, 16);
    // drain partly, then R6 lower threshold below level
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0);
    chk("R6 no event before write", evt, 0);
    step(0, 0, 1, 0, 2);
    chk("R6 event immediate", evt, 1);
    step(0, 0, 1, 0, 9);
    chk("R6 event drops on raise", evt, 0);
    // drain past empty
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 0);
    chk("R7 drained empty", empty, 1);
    chk("R8 ovf sticky", ovf, 1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      bit pu = (r < 55);
      bit po = ($urandom_range(0, 99) < 45);
      bit tw = ($urandom_range(0, 99) < 4);
      step(pu, po, tw, 8'($urandom), $urandom_range(0, 15));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule